// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block captures a stream of trace words into an on-chip RAM ring. While capture is enabled, every cycle that presents a valid trace word stores it at the write pointer, which then advances and wraps at the buffer depth. A sticky wrap flag records that old data has been overwritten. When the flag is set, the oldest surviving frame sits at the write pointer. When it is clear, the valid frames run from address 0 up to the write pointer minus one.

A trigger input marks one captured word. A programmable post-trigger count then sets how many further words are kept before capture freezes. This keeps a window of history around the event.

A simple register port reads the contents out. Each read of the data register returns the word at the read pointer and advances that pointer modulo the depth. Software can load the read pointer with the oldest frame and stream the whole ring. The trace clock and the register clock are the same clock. The depth must be a power of two.

Top module: `ctb_trace_buffer`

## Requirements
- R1: After reset, the status, write pointer, read pointer, control and trigger-count registers all read 0.
- R2: Register 0 reads the constant 0x7B1C0001. Register 1 reads the DEPTH parameter. Register 2 reads the trace word width TW.
- R3: Capture is active only when control bit 0 is 1 and status bit 2 is 0. In that case, each cycle with trc_valid high stores trc_word at the write pointer, and the pointer then advances modulo DEPTH. Otherwise the write pointer and the stored words do not change.
- R4: Status bit 1 (wrapped) is set when the write pointer advances from DEPTH-1 to 0. It stays set until register 6 is written. That write loads the write pointer and clears the bit.
- R5: A read of register 4 returns the stored word at the read pointer, zero-extended to 32 bits. The read pointer then advances modulo DEPTH.
- R6: Register 5 holds the read pointer. Writing it sets the read pointer, and reading it returns the current value.
- R7: A captured word with trigger_in high sets status bit 0 (triggered). That word is stored, followed by exactly N more captured words, where N is the value of register 7. After the last of these, status bit 2 (stopped) is set, capture ceases, and register 7 reads 0. Words presented after the stop are not stored.
- R8: Writing register 8 sets capture enable from bit 0 and clears status bits 0 and 2. No word is captured in a cycle that writes register 6 or register 8.
- R9: reg_rvalid is high exactly one cycle after each cycle with reg_rd high, and reg_rdata carries the result in that cycle. Unmapped addresses (9 to 15) read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for capture and the register port |
| rst | input | 1 | Synchronous active-high reset |
| trc_valid | input | 1 | A trace word is present this cycle |
| trc_word | input | TW | Trace word to capture |
| trigger_in | input | 1 | Marks the present trace word as the trigger |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read result valid, one cycle after reg_rd |

## Verification
The checker watches several properties on every cycle. It confirms the one-cycle read response, and that the wrap flag rises only when the write pointer leaves the last address. It also confirms that the write pointer holds still while capture is disabled or stopped, that stopping implies a trigger was seen, and that each data read advances the read pointer. Some behaviour only the bench scenarios can show: the stored contents coming back in oldest-first order after a wrap, the exact number of post-trigger words that are kept, and the way a control write clears the status and re-arms capture.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

    localparam logic [31:0] CTB_IDENT = 32'h7B1C_0001;

    typedef enum logic [3:0] {
        RA_IDENT   = 4'd0,
        RA_DEPTH   = 4'd1,
        RA_WIDTH   = 4'd2,
        RA_STATUS  = 4'd3,
        RA_DATA    = 4'd4,
        RA_RDPTR   = 4'd5,
        RA_WRPTR   = 4'd6,
        RA_TRIGCNT = 4'd7,
        RA_CTRL    = 4'd8
    } reg_addr_e;

    // bit 2 stopped, bit 1 wrapped, bit 0 triggered
    typedef struct packed {
        logic stopped;
        logic wrapped;
        logic triggered;
    } status_t;

    function automatic logic [31:0] status_word(status_t s);
        return {29'd0, s};
    endfunction

endpackage

// File: rtl/ctb_mem.sv
module ctb_mem #(
    parameter int DEPTH = 16,
    parameter int TW    = 20,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [TW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [TW-1:0] rdata
);
    logic [TW-1:0] ram [DEPTH];

    always_ff @(posedge clk) begin
        if (we) ram[waddr] <= wdata;
        if (re) rdata <= ram[raddr];
    end
endmodule

// File: rtl/ctb_capture.sv
module ctb_capture
    import ctb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TW    = 20,
    parameter int CNT_W = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             trc_valid,
    input  logic [TW-1:0]    trc_word,
    input  logic             trigger_in,
    input  logic             ptr_ld,
    input  logic [AW-1:0]    ptr_val,
    input  logic             cnt_ld,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             arm,
    output logic             mem_we,
    output logic [AW-1:0]    mem_waddr,
    output logic [TW-1:0]    mem_wdata,
    output logic [AW-1:0]    wp,
    output logic [CNT_W-1:0] cnt,
    output status_t          status
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic accept;
    assign accept    = en && !status.stopped && trc_valid && !ptr_ld && !arm;
    assign mem_we    = accept;
    assign mem_waddr = wp;
    assign mem_wdata = trc_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp     <= '0;
            cnt    <= '0;
            status <= '0;
        end else begin
            if (ptr_ld) begin
                wp             <= ptr_val;
                status.wrapped <= 1'b0;
            end else if (accept) begin
                wp <= (wp == LAST) ? '0 : wp + 1'b1;
                if (wp == LAST) status.wrapped <= 1'b1;
            end

            if (arm) begin
                status.triggered <= 1'b0;
                status.stopped   <= 1'b0;
            end else if (accept) begin
                if (status.triggered) begin
                    if (cnt <= CNT_W'(1)) status.stopped <= 1'b1;
                end else if (trigger_in) begin
                    status.triggered <= 1'b1;
                    if (cnt == '0) status.stopped <= 1'b1;
                end
            end

            if (cnt_ld)
                cnt <= cnt_val;
            else if (accept && status.triggered && cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/ctb_regif.sv
module ctb_regif
    import ctb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TW    = 20,
    parameter int CNT_W = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             reg_rvalid,
    output logic             en,
    output logic             ptr_ld,
    output logic [AW-1:0]    ptr_val,
    output logic             cnt_ld,
    output logic [CNT_W-1:0] cnt_val,
    output logic             arm,
    input  logic [AW-1:0]    wp,
    input  logic [CNT_W-1:0] cnt,
    input  status_t          status,
    output logic             mem_re,
    output logic [AW-1:0]    mem_raddr,
    input  logic [TW-1:0]    mem_q,
    output logic [AW-1:0]    rp
);
    localparam int PAD = 32 - TW;

    reg_addr_e   addr;
    logic [31:0] rd_mux;
    logic [31:0] hold_q;
    logic        data_sel_q;

    assign addr      = reg_addr_e'(reg_addr);
    assign ptr_ld    = reg_wr && addr == RA_WRPTR;
    assign ptr_val   = reg_wdata[AW-1:0];
    assign cnt_ld    = reg_wr && addr == RA_TRIGCNT;
    assign cnt_val   = reg_wdata[CNT_W-1:0];
    assign arm       = reg_wr && addr == RA_CTRL;
    assign mem_re    = reg_rd && addr == RA_DATA;
    assign mem_raddr = rp;

    always_comb begin
        case (addr)
            RA_IDENT:   rd_mux = CTB_IDENT;
            RA_DEPTH:   rd_mux = 32'(DEPTH);
            RA_WIDTH:   rd_mux = 32'(TW);
            RA_STATUS:  rd_mux = status_word(status);
            RA_RDPTR:   rd_mux = 32'(rp);
            RA_WRPTR:   rd_mux = 32'(wp);
            RA_TRIGCNT: rd_mux = 32'(cnt);
            RA_CTRL:    rd_mux = {31'd0, en};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rp         <= '0;
            en         <= 1'b0;
            reg_rvalid <= 1'b0;
            hold_q     <= '0;
            data_sel_q <= 1'b0;
        end else begin
            if (reg_wr && addr == RA_RDPTR)
                rp <= reg_wdata[AW-1:0];
            else if (mem_re)
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (arm) en <= reg_wdata[0];
            reg_rvalid <= reg_rd;
            hold_q     <= rd_mux;
            data_sel_q <= mem_re;
        end
    end

    assign reg_rdata = data_sel_q ? {{PAD{1'b0}}, mem_q} : hold_q;
endmodule

// File: rtl/ctb_trace_buffer.sv
module ctb_trace_buffer
    import ctb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TW    = 20,
    parameter int CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trc_valid,
    input  logic [TW-1:0] trc_word,
    input  logic          trigger_in,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          reg_rvalid
);
    localparam int AW = $clog2(DEPTH);

    logic             cap_en, ptr_ld, cnt_ld, arm;
    logic [AW-1:0]    ptr_val, wp, rp, mem_waddr, mem_raddr;
    logic [CNT_W-1:0] cnt_val, cnt;
    status_t          status;
    logic             mem_we, mem_re;
    logic [TW-1:0]    mem_wdata, mem_q;

    ctb_capture #(.DEPTH(DEPTH), .TW(TW), .CNT_W(CNT_W)) u_capture (
        .clk(clk), .rst(rst), .en(cap_en),
        .trc_valid(trc_valid), .trc_word(trc_word), .trigger_in(trigger_in),
        .ptr_ld(ptr_ld), .ptr_val(ptr_val), .cnt_ld(cnt_ld), .cnt_val(cnt_val),
        .arm(arm), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .wp(wp), .cnt(cnt), .status(status)
    );

    ctb_mem #(.DEPTH(DEPTH), .TW(TW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .re(mem_re), .raddr(mem_raddr), .rdata(mem_q)
    );

    ctb_regif #(.DEPTH(DEPTH), .TW(TW), .CNT_W(CNT_W)) u_regif (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .en(cap_en), .ptr_ld(ptr_ld), .ptr_val(ptr_val),
        .cnt_ld(cnt_ld), .cnt_val(cnt_val), .arm(arm), .wp(wp), .cnt(cnt),
        .status(status), .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_q(mem_q),
        .rp(rp)
    );
endmodule

// File: rtl/ctb_checker.sv
module ctb_checker
    import ctb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_rd,
    input logic          reg_wr,
    input logic [3:0]    reg_addr,
    input logic          reg_rvalid,
    input logic          en,
    input logic [AW-1:0] wp,
    input logic [AW-1:0] rp,
    input status_t       status
);
    AST_RVALID_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> reg_rvalid);  // R9
    AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> !reg_rvalid);  // R9
    AST_WRAP_AT_END: assert property (@(posedge clk) disable iff (rst)
        $rose(status.wrapped) |-> $past(wp) == AW'(DEPTH - 1));  // R4
    AST_WP_HELD_IDLE: assert property (@(posedge clk) disable iff (rst)
        ((!en || status.stopped) && !reg_wr) |=> $stable(wp));  // R3
    AST_STOP_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (rst)
        status.stopped |-> status.triggered);  // R7
    AST_RP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && reg_addr == 4'd4)
        |=> rp == (($past(rp) == AW'(DEPTH - 1)) ? '0 : $past(rp) + 1'b1));  // R5
endmodule

bind ctb_trace_buffer ctb_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_rvalid(reg_rvalid), .en(cap_en), .wp(wp), .rp(rp), .status(status)
);

// File: tb/ctb_trace_buffer_tb_top.sv
module ctb_trace_buffer_tb_top;
    localparam int CLK_P = 10;
    localparam int DEPTH = 16;
    localparam int TW    = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trc_valid = 1'b0;
    logic [TW-1:0] trc_word = '0;
    logic          trigger_in = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          reg_rvalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    // reference state built from the requirements
    logic [31:0] m_ram [DEPTH];
    int  m_wp = 0, m_rp = 0, m_cnt = 0, k = 0;
    bit  m_en = 0, m_wrap = 0, m_trig = 0, m_stop = 0;

    always #(CLK_P/2) clk = ~clk;

    ctb_trace_buffer #(.DEPTH(DEPTH), .TW(TW)) dut_i (
        .clk(clk), .rst(rst), .trc_valid(trc_valid), .trc_word(trc_word),
        .trigger_in(trigger_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid)
    );

    function automatic logic [TW-1:0] word_of(int n);
        return TW'(n * 32'h137 + 32'h5A5A5);
    endfunction

    task automatic push(bit trig);
        logic [TW-1:0] w = word_of(k);
        k++;
        @(negedge clk);
        trc_valid = 1'b1; trc_word = w; trigger_in = trig;
        if (m_en && !m_stop) begin
            m_ram[m_wp] = 32'(w);
            if (m_trig) begin
                if (m_cnt <= 1) m_stop = 1;
                if (m_cnt != 0) m_cnt--;
            end else if (trig) begin
                m_trig = 1;
                if (m_cnt == 0) m_stop = 1;
            end
            if (m_wp == DEPTH-1) m_wrap = 1;
            m_wp = (m_wp + 1) % DEPTH;
        end
        @(negedge clk);
        trc_valid = 1'b0; trigger_in = 1'b0;
    endtask

    task automatic reg_write(int a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        case (a)
            5: m_rp = int'(d) % DEPTH;
            6: begin m_wp = int'(d) % DEPTH; m_wrap = 0; end
            7: m_cnt = int'(d[15:0]);
            8: begin m_en = d[0]; m_trig = 0; m_stop = 0; end
            default: ;
        endcase
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(int a, string tag);
        logic [31:0] e;
        case (a)
            0: e = 32'h7B1C_0001;
            1: e = 32'(DEPTH);
            2: e = 32'(TW);
            3: e = {29'd0, m_stop, m_wrap, m_trig};
            4: begin e = m_ram[m_rp]; m_rp = (m_rp + 1) % DEPTH; end
            5: e = 32'(m_rp);
            6: e = 32'(m_wp);
            7: e = 32'(m_cnt);
            8: e = {31'd0, m_en};
            default: e = '0;
        endcase
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 4'(a);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // monitor: pops expected results as the design returns them
    logic [31:0] mon_e;
    string       mon_t;
    always @(posedge clk) begin
        #(CLK_P/4);
        if (!rst && reg_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 rvalid with no pending read: actual %h expected none", reg_rdata);
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                if (reg_rdata !== mon_e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", mon_t, reg_rdata, mon_e);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        reg_read(3, "R1 status");
        reg_read(6, "R1 write pointer");
        reg_read(5, "R1 read pointer");
        reg_read(8, "R1 control");
        reg_read(7, "R1 trigger count");
        // R2 constants, R9 unmapped
        reg_read(0, "R2 ident");
        reg_read(1, "R2 depth");
        reg_read(2, "R2 width");
        reg_write(12, 32'hFFFF_FFFF);
        reg_read(12, "R9 unmapped");
        reg_read(3, "R9 unmapped write no effect");
        // R3 disabled capture is ignored
        for (int i = 0; i < 3; i++) push(0);
        reg_read(6, "R3 disabled wp");
        // R3 enabled capture
        reg_write(7, 32'd100);
        reg_write(8, 32'd1);
        for (int i = 0; i < 5; i++) push(0);
        reg_read(6, "R3 wp after five");
        reg_read(7, "R7 count idle before trigger");
        // R6 read pointer, R5 data stream
        reg_write(5, 32'd0);
        reg_read(5, "R6 rp readback");
        for (int i = 0; i < 5; i++) reg_read(4, "R5 data");
        // R4 wrap
        for (int i = 0; i < 13; i++) push(0);
        reg_read(3, "R4 wrapped status");
        reg_read(6, "R4 wp after wrap");
        reg_write(5, 32'(m_wp));
        for (int i = 0; i < DEPTH; i++) reg_read(4, "R5 oldest-first data");
        reg_read(5, "R5 rp modulo depth");
        reg_write(6, 32'd0);
        reg_read(3, "R4 wrap cleared");
        reg_read(6, "R4 wp loaded");
        // R7 trigger window
        reg_write(7, 32'd3);
        push(0); push(0); push(1);
        for (int i = 0; i < 6; i++) push(0);
        reg_read(3, "R7 stopped status");
        reg_read(6, "R7 wp frozen");
        reg_read(7, "R7 count exhausted");
        reg_write(5, 32'(m_wp));
        reg_read(4, "R7 word after stop not stored");
        // R8 re-arm
        reg_write(8, 32'd1);
        reg_read(3, "R8 status cleared");
        push(0);
        reg_read(6, "R8 capture resumes");
        reg_write(8, 32'd0);
        push(0);
        reg_read(6, "R8 disable holds wp");
        reg_read(8, "R8 control readback");
        // R7 zero count: only the trigger word is kept
        reg_write(7, 32'd0);
        reg_write(8, 32'd1);
        push(1); push(0);
        reg_read(3, "R7 zero-count stop");
        reg_read(6, "R7 zero-count wp");
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9 missing responses: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule